// File: doc/BRIEF.md
# Serial Character Transmitter with Selectable Parity

This block turns bytes written by a host into asynchronous serial characters on a single output line. One 8-bit control/status register sets the character length (seven, eight or nine data bits) and whether a parity bit follows the data. The parity bit can be computed as odd or even, or it can be forced to one or to zero. In nine-bit mode the bit that otherwise picks the parity flavour instead supplies the ninth data bit, and no parity bit is sent.

The host writes the control register, then writes a data byte into a one-entry holding buffer. On the next baud tick with the shifter free, the byte moves into the shifter and the character is sent. Each line bit lasts from one baud tick to the next. A buffer-empty flag, in the status register and on its own pin, tells the host when it may write the next byte. If the host keeps the buffer full, characters follow each other with no idle bit between them.

Top module: `usart_frame_tx`

## Requirements
- R1: After reset the status read is 8'h01: all writable control bits are 0, the two unused flag bits are 0, and tx_empty is 1. txd is high.
- R2: The control register uses bit 7 = parity on, bit 6 = parity select high, bit 5 = ninth data bit / parity select low, bits 4:3 = length code. Bits 2:0 are read-only, and writes to them have no effect. Bits 2 and 1 read 0 and bit 0 reads tx_empty. A write with reg_sel=0 updates bits 7:3 on the next cycle.
- R3: Length code 00 sends 8 data bits, 01 sends 7 (bits 6:0), 10 sends 9, and the reserved code 11 behaves exactly like 00.
- R4: A character is one low start bit, then the data bits LSB first, then the optional extra bit, then one high stop bit. txd changes only in the cycle after a cycle in which baud_tick is high.
- R5: In 7- and 8-bit modes with bit 7 = 0, no parity bit is sent: the stop bit directly follows the last data bit.
- R6: With parity on in 7- and 8-bit modes, the select pair {bit 6, bit 5} gives 00 = odd (the ones among the sent data bits plus parity is an odd count), 01 = even, 10 = constant 1, 11 = constant 0. Only the data bits actually sent count.
- R7: In 9-bit mode, control bit 5 is sent after the eight data bits, and no parity bit is sent whatever bit 7 holds.
- R8: tx_empty goes to 0 in the cycle after a data write (reg_sel=1) and returns to 1 in the cycle after the baud tick that moves the byte into the shifter, unless another data write happened in that same cycle.
- R9: A held byte starts its character on the first baud tick at which the shifter is idle or is finishing its stop bit, so buffered characters go back to back. With nothing held, txd stays high.
- R10: Length, parity and ninth-bit settings are captured when a character starts. Control writes made during the character do not change it.
- R11: A data write while the buffer is already full replaces the held byte, and the newest byte is the one sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Write target: 0 control register, 1 data buffer |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control/status register read value |
| baud_tick | input | 1 | One-cycle pulse marking a bit boundary |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Holding buffer empty |

## Verification
Assertions check on every cycle that txd rests high when no character is active, that the line moves only after a baud tick, that a character always begins with a low start bit, that the buffer-empty flag follows data writes and loads, and that control writes land in the register. Bit order, the four parity flavours, the length decode with its reserved code, nine-bit substitution, settings latched at the start of a character, and the newest byte winning in a full buffer only show up in the bench. There, whole characters are captured and compared with characters built from the requirements, under random settings, random data and random tick spacing.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      LEN_EIGHT = 2'b00,
      LEN_SEVEN = 2'b01,
      LEN_NINE  = 2'b10,
      LEN_RSVD  = 2'b11
   } len_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_ONE   = 2'b10,
      PAR_ZERO  = 2'b11
   } par_e;

   // writable part of the control register, bit 7 down to bit 3
   typedef struct packed {
      logic par_on;
      logic sel_hi;
      logic sel_lo_x9;
      len_e len;
   } ctrl_t;

endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
   parameter int W = 8
) (
   input  logic [W-1:0] bits,
   input  logic [W-1:0] keep,
   output logic         odd_ones
);
   logic [W:0] chain;

   assign chain[0] = 1'b0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_chain
         assign chain[i+1] = chain[i] ^ (bits[i] & keep[i]);
      end
   endgenerate

   assign odd_ones = chain[W];

endmodule

// File: rtl/utx_regs.sv
module utx_regs
   import utx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              load,
   output ctrl_t             ctrl,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_full,
   output logic [REG_W-1:0]  rd_data
);
   logic  wr_ctrl, wr_buf;
   ctrl_t ctrl_q;
   logic [DATA_W-1:0] hold_q;
   logic  full_q;

   assign wr_ctrl = reg_wr && !reg_sel;
   assign wr_buf  = reg_wr &&  reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'(wr_data[REG_W-1:3]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_buf) begin
            hold_q <= wr_data[DATA_W-1:0];
         end
         if (wr_buf) begin
            full_q <= 1'b1;
         end else if (load) begin
            full_q <= 1'b0;
         end
      end
   end

   assign ctrl      = ctrl_q;
   assign hold_data = hold_q;
   assign hold_full = full_q;
   assign rd_data   = {ctrl_q, 1'b0, 1'b0, !full_q};

   // R8: a data write leaves the buffer full
   a_r8_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_buf |=> !rd_data[0]);

   // R8: a load with no competing write empties the buffer
   a_r8_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_buf) |=> rd_data[0]);

   // R2: control write lands in bits 7:3
   a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (rd_data[REG_W-1:3] == $past(wr_data[REG_W-1:3])));

endmodule

// File: rtl/utx_framer.sv
module utx_framer
   import utx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = DATA_W + 3,
   parameter int CNT_W   = $clog2(FRAME_W)
) (
   input  ctrl_t              ctrl,
   input  logic [DATA_W-1:0]  data,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   rem_bits
);
   logic [CNT_W-1:0]  n_data;
   logic [DATA_W-1:0] keep;
   logic              nine, extra_on, extra_bit, odd_ones;
   par_e              flavour;

   always_comb begin
      nine = 1'b0;
      unique case (ctrl.len)
         LEN_SEVEN: begin
            n_data = CNT_W'(DATA_W - 1);
            keep   = {1'b0, {(DATA_W-1){1'b1}}};
         end
         LEN_NINE: begin
            n_data = CNT_W'(DATA_W);
            keep   = '1;
            nine   = 1'b1;
         end
         default: begin
            n_data = CNT_W'(DATA_W);
            keep   = '1;
         end
      endcase
   end

   utx_parity #(.W(DATA_W)) u_par (
      .bits     (data),
      .keep     (keep),
      .odd_ones (odd_ones)
   );

   assign flavour  = par_e'({ctrl.sel_hi, ctrl.sel_lo_x9});
   assign extra_on = nine || ctrl.par_on;

   always_comb begin
      unique case (flavour)
         PAR_ODD:  extra_bit = !odd_ones;
         PAR_EVEN: extra_bit = odd_ones;
         PAR_ONE:  extra_bit = 1'b1;
         default:  extra_bit = 1'b0;
      endcase
      if (nine) begin
         extra_bit = ctrl.sel_lo_x9;
      end
   end

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (CNT_W'(i) < n_data) begin
            frame[1+i] = data[i];
         end
      end
      if (extra_on) begin
         frame[1+n_data] = extra_bit;
      end
      rem_bits = n_data + CNT_W'(extra_on) + CNT_W'(1);
   end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int FRAME_W = 11,
   parameter int CNT_W   = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               avail,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   rem_bits,
   output logic               load,
   output logic               txd
);
   logic               active_q, txd_q, slot_free;
   logic [CNT_W-1:0]   rem_q;
   logic [FRAME_W-1:0] sh_q;

   assign slot_free = !active_q || (rem_q == '0);
   assign load      = tick && avail && slot_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         txd_q    <= 1'b1;
         rem_q    <= '0;
         sh_q     <= '1;
      end else if (tick) begin
         if (slot_free) begin
            if (avail) begin
               txd_q    <= frame[0];
               sh_q     <= {1'b1, frame[FRAME_W-1:1]};
               rem_q    <= rem_bits;
               active_q <= 1'b1;
            end else begin
               txd_q    <= 1'b1;
               active_q <= 1'b0;
            end
         end else begin
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            rem_q <= rem_q - CNT_W'(1);
         end
      end
   end

   assign txd = txd_q;

   // R9: line rests high when no character is in flight
   a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> txd);

   // R4: line only moves after a baud tick
   a_r4_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(txd));

   // R4: every character opens with a low start bit
   a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);

endmodule

// File: rtl/usart_frame_tx.sv
module usart_frame_tx
   import utx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   input  logic        baud_tick,
   output logic        txd,
   output logic        tx_empty
);
   localparam int FRAME_W = DATA_W + 3;
   localparam int CNT_W   = $clog2(FRAME_W);

   generate
      if (DATA_W < 2 || DATA_W > REG_W) begin : g_bad_width
         $error("DATA_W must lie between 2 and the register width");
      end
   endgenerate

   ctrl_t              ctrl;
   logic [DATA_W-1:0]  hold_data;
   logic               hold_full, load;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   rem_bits;

   utx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .wr_data   (wr_data),
      .load      (load),
      .ctrl      (ctrl),
      .hold_data (hold_data),
      .hold_full (hold_full),
      .rd_data   (rd_data)
   );

   utx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
      .ctrl     (ctrl),
      .data     (hold_data),
      .frame    (frame),
      .rem_bits (rem_bits)
   );

   utx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .avail    (hold_full),
      .frame    (frame),
      .rem_bits (rem_bits),
      .load     (load),
      .txd      (txd)
   );

   assign tx_empty = !hold_full;

endmodule

// File: tb/sim_usart_frame_tx.sv
`timescale 1ns/1ps
module sim_usart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       baud_tick = 1'b0;
   logic [7:0] rd_data;
   logic       txd, tx_empty;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   usart_frame_tx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .baud_tick (baud_tick),
      .txd       (txd),
      .tx_empty  (tx_empty)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; wr_data = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // one baud tick, then a random wait; returns at a falling edge
   task automatic pulse(input int gap);
      @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   // expected character from the requirements; returns line bit count
   function automatic int build(input logic [7:0] c, input logic [7:0] d,
                                output logic [10:0] f);
      int nd; logic nine, ex, xb, p;
      nine = (c[4:3] == 2'b10);
      nd   = (c[4:3] == 2'b01) ? 7 : 8;
      p = 1'b0;
      for (int i = 0; i < nd; i++) p ^= d[i];
      f = '1; f[0] = 1'b0;
      for (int i = 0; i < nd; i++) f[1+i] = d[i];
      ex = nine || c[7];
      case (c[6:5])
         2'b00: xb = ~p;
         2'b01: xb = p;
         2'b10: xb = 1'b1;
         default: xb = 1'b0;
      endcase
      if (nine) xb = c[5];
      if (ex) f[1+nd] = xb;
      return nd + (ex ? 1 : 0) + 2;
   endfunction

   function automatic string tag(input logic [7:0] c);
      if (c[4:3] == 2'b10) return "R7";
      if (c[4:3] == 2'b11) return "R3";
      if (c[7])            return "R6";
      return "R5";
   endfunction

   task automatic run_frame(input logic [7:0] c, input logic [7:0] d,
                            input bit mid, input bit rnd_gap);
      logic [10:0] f; int n;
      wr(1'b0, c);
      wr(1'b1, d);
      check("R8 empty low after write", tx_empty, 0);
      n = build(c, d, f);
      for (int k = 0; k < n; k++) begin
         pulse(rnd_gap ? int'($urandom_range(0, 3)) : 0);
         if (k == 0) check("R8 empty after load", tx_empty, 1);
         if (mid && k == 1) wr(1'b0, ~c);
         check($sformatf("R4/%s bit %0d c=%0h d=%0h", tag(c), k, c, d), txd, f[k]);
      end
      pulse(0);
      check("R9 idle after stop", txd, 1);
   endtask

   initial begin
      logic [10:0] f1, f3; int n1, n3;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      check("R1 status after reset", rd_data, 8'h01);
      check("R1 txd after reset", txd, 1);
      check("R1 empty after reset", tx_empty, 1);
      rst_n = 1'b1;
      @(negedge clk);
      pulse(1);
      check("R9 idle with nothing held", txd, 1);

      // R2: read-only bits ignore writes
      wr(1'b0, 8'hFF);
      check("R2 read-only bits", rd_data, 8'hF9);
      wr(1'b0, 8'h07);
      check("R2 low bits write ignored", rd_data, 8'h01);
      wr(1'b0, 8'hA8);
      check("R2 field placement", rd_data, 8'hA9);

      // directed corners
      run_frame(8'h00, 8'hA5, 0, 0);        // R3 8 bits, R5 no parity
      run_frame(8'h08, 8'hFF, 0, 0);        // R3 7 bits, bit 7 dropped
      run_frame(8'h88, 8'h80, 0, 0);        // R6 odd over 7 bits only
      run_frame(8'hA8, 8'h80, 0, 0);        // R6 even over 7 bits
      run_frame(8'hC0, 8'h00, 0, 0);        // R6 constant 1
      run_frame(8'hE0, 8'hFF, 0, 0);        // R6 constant 0
      run_frame(8'h30, 8'h3C, 0, 0);        // R7 ninth bit 1
      run_frame(8'h90, 8'h3C, 0, 0);        // R7 ninth 0, parity bit ignored
      run_frame(8'h98, 8'h5A, 0, 0);        // R3 reserved code as 8 bits
      run_frame(8'h88, 8'h13, 1, 0);        // R10 control change mid character
      run_frame(8'h30, 8'hC3, 1, 1);        // R10 with nine-bit mode

      // R9/R11 back to back with replaced buffer
      wr(1'b0, 8'h80);
      n1 = build(8'h80, 8'h61, f1);
      n3 = build(8'h80, 8'h9E, f3);
      wr(1'b1, 8'h61);
      pulse(0);
      check("R4 start of first", txd, f1[0]);
      wr(1'b1, 8'h22);
      wr(1'b1, 8'h9E);
      check("R8 empty low while busy", tx_empty, 0);
      for (int k = 1; k < n1; k++) begin
         pulse(0);
         check($sformatf("R4 first bit %0d", k), txd, f1[k]);
      end
      pulse(0);
      check("R9 back to back start", txd, 0);
      check("R8 empty after second load", tx_empty, 1);
      for (int k = 1; k < n3; k++) begin
         pulse(1);
         check($sformatf("R11 newest byte bit %0d", k), txd, f3[k]);
      end
      pulse(0);
      check("R9 idle after pair", txd, 1);

      // random settings and data
      for (int r = 0; r < 60; r++) begin
         logic [7:0] c, d;
         c = 8'($urandom) & 8'hF8;
         d = 8'($urandom);
         run_frame(c, d, ($urandom_range(0, 3) == 0), 1);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule